// File: doc/BRIEF.md
# Serial Display Video Timing Sequencer

This block produces the line and frame timing events that a serial display link transmitter needs in video mode. Horizontal lengths (sync width, back porch, active span and whole line) are given in lane byte clock cycles. Vertical lengths (sync, back porch, active and front porch) are given in lines. Every cycle the sequencer reports where the link is in the frame: a region code, a one-cycle strobe at the start of each line, a strobe at the end of the horizontal sync width when sync pulses are selected, an active-pixel window, and a flag that says whether the link may drop to low power.

The configuration inputs are sampled into shadow registers while the sequencer is powered down, and again on the last cycle of every frame. A change made mid-frame therefore shows up only from the first cycle of the next frame. A power-up input gates the whole sequencer. While it is low, the counters sit at the first cycle of the first line and every output is quiet.

Top module: `vid_timing_seq`

## Requirements
- R1: While `powerUp` is low, `syncStart`, `syncEnd`, `activeWin` and `lpAllowed` are 0, `region` is 0 and the counters are held. The first cycle with `powerUp` high is cycle 0 of line 0 of a frame.
- R2: A line lasts `hlineCyc` cycles, and a value of 0 counts as 1. `syncStart` is high on cycle 0 of every line.
- R3: Inside a line, cycles below `hsaCyc` are sync and the next `hbpCyc` cycles are back porch. The next `hactCyc` cycles are active, and the rest of the line is front porch. When the first three add up to the line length or more, the front porch is empty and the later parts are cut off at the line end.
- R4: A frame is `vsaLines` sync lines, then `vbpLines` back-porch lines, then `vactLines` active lines, then `vfpLines` front-porch lines. A total of 0 counts as one line, and that line falls in the front porch.
- R5: `activeWin` is high exactly on the active cycles of active lines.
- R6: `region` encodes the position: 0 vertical sync line, 1 vertical back-porch line, 2 vertical front-porch line. Inside active lines the codes are 3 horizontal sync, 4 horizontal back porch, 5 horizontal front porch and 6 active pixels.
- R7: `modeSel` value 0 (sync pulses) makes `syncEnd` pulse on cycle `hsaCyc` of each line, provided that cycle lies inside the line. Values 1 (sync events), 2 (burst) and 3 never raise `syncEnd`.
- R8: `lpAllowed` equals bit `region` of `lpMask` for region codes 0 to 5 and is 0 in region 6. In mode 2 it is also forced high in region 5.
- R9: Configuration is sampled while powered down and on the last cycle of each frame. A change at any other time has no effect on the outputs until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerUp | input | 1 | Runs the sequencer when high |
| hsaCyc | input | H_W | Horizontal sync width, cycles |
| hbpCyc | input | H_W | Horizontal back porch, cycles |
| hactCyc | input | H_W | Horizontal active span, cycles |
| hlineCyc | input | H_W | Whole line, cycles |
| vsaLines | input | V_W | Vertical sync, lines |
| vbpLines | input | V_W | Vertical back porch, lines |
| vactLines | input | V_W | Vertical active, lines |
| vfpLines | input | V_W | Vertical front porch, lines |
| modeSel | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| lpMask | input | 6 | Low-power permission per region code 0..5 |
| syncStart | output | 1 | Line start strobe |
| syncEnd | output | 1 | End of horizontal sync strobe (pulse mode) |
| region | output | 3 | Current region code |
| activeWin | output | 1 | Active pixel window |
| lpAllowed | output | 1 | Low-power entry permitted |

## Verification
The bench targets four places where the sequencer can go wrong. The first is a configuration change in the middle of a frame: a design that applies it at once produces a shortened or stretched line before the frame boundary. The second is a line whose sync, porch and active span overrun its length: a design that computes the front porch by wrapping subtraction either marks wrong regions or never ends the line. The third is a zero-length line and an empty frame: a design without the one-cycle floor stalls or counts through the full counter range. The fourth is the set of mode differences: a design that ignores the mode emits `syncEnd` in sync-event or burst mode, or fails to open low power in the burst front porch. Dropping power mid-frame is also exercised, because a design that does not restart from line 0 resumes at the stale position.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [2:0] {
    RG_VSYNC  = 3'd0,
    RG_VBACK  = 3'd1,
    RG_VFRONT = 3'd2,
    RG_HSYNC  = 3'd3,
    RG_HBACK  = 3'd4,
    RG_HFRONT = 3'd5,
    RG_PIXEL  = 3'd6
  } region_e;

  localparam logic [1:0] MODE_PULSE = 2'd0;
  localparam logic [1:0] MODE_EVENT = 2'd1;
  localparam logic [1:0] MODE_BURST = 2'd2;

  localparam int NUM_VSEG = 4;
  localparam int NUM_LP   = 6;

  typedef struct packed {
    logic clear;      // hold counters at frame origin
    logic load;       // capture configuration into shadow
    logic lineAdv;    // close the current line
    logic frameWrap;  // close the current frame
  } seq_ctl_t;

endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic     powerUp,
  input  logic     lineEnd,
  input  logic     frameEnd,
  output seq_ctl_t ctl
);

  logic lastCycle;

  assign lastCycle = lineEnd & frameEnd;

  always_comb begin
    ctl           = '0;
    ctl.clear     = ~powerUp;
    ctl.lineAdv   = powerUp & lineEnd;
    ctl.frameWrap = powerUp & lastCycle;
    ctl.load      = ~powerUp | lastCycle;
  end

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int H_W = 16,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           powerUp,
  input  seq_ctl_t       ctl,
  input  logic [H_W-1:0] hsaCyc,
  input  logic [H_W-1:0] hbpCyc,
  input  logic [H_W-1:0] hactCyc,
  input  logic [H_W-1:0] hlineCyc,
  input  logic [V_W-1:0] vsaLines,
  input  logic [V_W-1:0] vbpLines,
  input  logic [V_W-1:0] vactLines,
  input  logic [V_W-1:0] vfpLines,
  input  logic [1:0]     modeSel,
  input  logic [5:0]     lpMask,
  output logic           lineEnd,
  output logic           frameEnd,
  output logic           syncStart,
  output logic           syncEnd,
  output logic [2:0]     region,
  output logic           activeWin,
  output logic           lpAllowed
);

  localparam int HE_W = H_W + 2;
  localparam int VE_W = V_W + 2;
  localparam logic [H_W-1:0]  H_ONE = {{(H_W-1){1'b0}}, 1'b1};
  localparam logic [VE_W-1:0] V_ONE = {{(VE_W-1){1'b0}}, 1'b1};

  // shadow configuration
  logic [H_W-1:0] sHsa, sHbp, sHact, sHline;
  logic [NUM_VSEG-1:0][V_W-1:0] sVLen, vLenIn;
  logic [1:0] sMode;
  logic [NUM_LP-1:0] sMask;

  // position counters
  logic [H_W-1:0]  hCnt;
  logic [VE_W-1:0] vCnt;

  // derived boundaries
  logic [H_W-1:0]  lineLast;
  logic [HE_W-1:0] hSyncEdge, hBackEdge, hActEdge, hCntW;
  logic [NUM_VSEG-1:0][VE_W-1:0] vEdge;
  logic [VE_W-1:0] vAcc, frameLast;

  region_e rg;
  logic    maskBit;

  assign vLenIn = {vfpLines, vactLines, vbpLines, vsaLines};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sHsa   <= '0;
      sHbp   <= '0;
      sHact  <= '0;
      sHline <= '0;
      sVLen  <= '0;
      sMode  <= '0;
      sMask  <= '0;
    end else if (ctl.load) begin
      sHsa   <= hsaCyc;
      sHbp   <= hbpCyc;
      sHact  <= hactCyc;
      sHline <= hlineCyc;
      sVLen  <= vLenIn;
      sMode  <= modeSel;
      sMask  <= lpMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (ctl.lineAdv) begin
      hCnt <= '0;
      vCnt <= ctl.frameWrap ? '0 : vCnt + V_ONE;
    end else begin
      hCnt <= hCnt + H_ONE;
    end
  end

  // horizontal boundaries, widened so overlong sums cannot wrap
  assign lineLast  = (sHline == '0) ? '0 : sHline - H_ONE;
  assign hSyncEdge = {2'b00, sHsa};
  assign hBackEdge = hSyncEdge + {2'b00, sHbp};
  assign hActEdge  = hBackEdge + {2'b00, sHact};
  assign hCntW     = {2'b00, hCnt};

  // cumulative vertical boundaries in frame order
  always_comb begin
    vAcc  = '0;
    vEdge = '0;
    for (int i = 0; i < NUM_VSEG; i++) begin
      vAcc     = vAcc + {2'b00, sVLen[i]};
      vEdge[i] = vAcc;
    end
  end

  assign frameLast = (vEdge[NUM_VSEG-1] == '0) ? '0 : vEdge[NUM_VSEG-1] - V_ONE;
  assign lineEnd   = (hCnt == lineLast);
  assign frameEnd  = (vCnt == frameLast);

  always_comb begin
    if (vCnt < vEdge[0])      rg = RG_VSYNC;
    else if (vCnt < vEdge[1]) rg = RG_VBACK;
    else if (vCnt < vEdge[2]) begin
      if (hCntW < hSyncEdge)      rg = RG_HSYNC;
      else if (hCntW < hBackEdge) rg = RG_HBACK;
      else if (hCntW < hActEdge)  rg = RG_PIXEL;
      else                        rg = RG_HFRONT;
    end else                  rg = RG_VFRONT;
  end

  always_comb begin
    case (rg)
      RG_VSYNC:  maskBit = sMask[0];
      RG_VBACK:  maskBit = sMask[1];
      RG_VFRONT: maskBit = sMask[2];
      RG_HSYNC:  maskBit = sMask[3];
      RG_HBACK:  maskBit = sMask[4];
      RG_HFRONT: maskBit = sMask[5] | (sMode == MODE_BURST);
      default:   maskBit = 1'b0;
    endcase
  end

  assign syncStart = powerUp & (hCnt == '0);
  assign syncEnd   = powerUp & (sMode == MODE_PULSE) & (hCntW == hSyncEdge);
  assign region    = powerUp ? rg : RG_VSYNC;
  assign activeWin = powerUp & (rg == RG_PIXEL);
  assign lpAllowed = powerUp & maskBit;

endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vtg_pkg::*;
#(
  parameter int H_W = 16,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           powerUp,
  input  logic [H_W-1:0] hsaCyc,
  input  logic [H_W-1:0] hbpCyc,
  input  logic [H_W-1:0] hactCyc,
  input  logic [H_W-1:0] hlineCyc,
  input  logic [V_W-1:0] vsaLines,
  input  logic [V_W-1:0] vbpLines,
  input  logic [V_W-1:0] vactLines,
  input  logic [V_W-1:0] vfpLines,
  input  logic [1:0]     modeSel,
  input  logic [5:0]     lpMask,
  output logic           syncStart,
  output logic           syncEnd,
  output logic [2:0]     region,
  output logic           activeWin,
  output logic           lpAllowed
);

  seq_ctl_t ctl;
  logic     lineEnd;
  logic     frameEnd;
  logic     cfgLoad;

  assign cfgLoad = ctl.load;

  vtg_ctrl u_ctrl (
    .powerUp  (powerUp),
    .lineEnd  (lineEnd),
    .frameEnd (frameEnd),
    .ctl      (ctl)
  );

  vtg_datapath #(.H_W(H_W), .V_W(V_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .powerUp   (powerUp),
    .ctl       (ctl),
    .hsaCyc    (hsaCyc),
    .hbpCyc    (hbpCyc),
    .hactCyc   (hactCyc),
    .hlineCyc  (hlineCyc),
    .vsaLines  (vsaLines),
    .vbpLines  (vbpLines),
    .vactLines (vactLines),
    .vfpLines  (vfpLines),
    .modeSel   (modeSel),
    .lpMask    (lpMask),
    .lineEnd   (lineEnd),
    .frameEnd  (frameEnd),
    .syncStart (syncStart),
    .syncEnd   (syncEnd),
    .region    (region),
    .activeWin (activeWin),
    .lpAllowed (lpAllowed)
  );

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       powerUp,
  input logic [1:0] modeSel,
  input logic       cfgLoad,
  input logic       lineEnd,
  input logic       syncStart,
  input logic       syncEnd,
  input logic [2:0] region,
  input logic       activeWin,
  input logic       lpAllowed
);

  logic [1:0] capMode;
  logic       prevRun;
  logic       prevLineEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMode     <= MODE_PULSE;
      prevRun     <= 1'b0;
      prevLineEnd <= 1'b0;
    end else begin
      if (cfgLoad) capMode <= modeSel;
      prevRun     <= powerUp;
      prevLineEnd <= lineEnd;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !powerUp |-> (!syncStart && !syncEnd && !activeWin && !lpAllowed && region == 3'd0)) // R1
    else $error("idle outputs not quiet");

  AST_LINE_START: assert property (@(posedge clk) disable iff (!rstN)
    (powerUp && prevRun && syncStart) |-> prevLineEnd) // R2
    else $error("line start without preceding line end");

  AST_PIXEL_NO_LP: assert property (@(posedge clk) disable iff (!rstN)
    activeWin |-> (!lpAllowed && region == 3'd6)) // R5
    else $error("low power or wrong region inside active window");

  AST_EVENT_NO_END: assert property (@(posedge clk) disable iff (!rstN)
    syncEnd |-> (capMode == MODE_PULSE)) // R7
    else $error("sync end strobe outside pulse mode");

endmodule

bind vid_timing_seq vtg_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerUp   (powerUp),
  .modeSel   (modeSel),
  .cfgLoad   (cfgLoad),
  .lineEnd   (lineEnd),
  .syncStart (syncStart),
  .syncEnd   (syncEnd),
  .region    (region),
  .activeWin (activeWin),
  .lpAllowed (lpAllowed)
);

// File: tb/vid_timing_seq_tb.sv
`timescale 1ns/1ps
module vid_timing_seq_tb;

  localparam int H_W = 16;
  localparam int V_W = 12;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           powerUp = 1'b0;
  logic [H_W-1:0] hsaCyc = '0, hbpCyc = '0, hactCyc = '0, hlineCyc = '0;
  logic [V_W-1:0] vsaLines = '0, vbpLines = '0, vactLines = '0, vfpLines = '0;
  logic [1:0]     modeSel = '0;
  logic [5:0]     lpMask = '0;
  logic           syncStart, syncEnd, activeWin, lpAllowed;
  logic [2:0]     region;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference model state
  int mh = 0, mv = 0;
  int sHsa = 0, sHbp = 0, sHact = 0, sHline = 0;
  int sVsa = 0, sVbp = 0, sVact = 0, sVfp = 0, sMode = 0, sMask = 0;

  always #10 clk = ~clk;

  vid_timing_seq #(.H_W(H_W), .V_W(V_W)) u_dut (
    .clk(clk), .rstN(rstN), .powerUp(powerUp),
    .hsaCyc(hsaCyc), .hbpCyc(hbpCyc), .hactCyc(hactCyc), .hlineCyc(hlineCyc),
    .vsaLines(vsaLines), .vbpLines(vbpLines), .vactLines(vactLines), .vfpLines(vfpLines),
    .modeSel(modeSel), .lpMask(lpMask),
    .syncStart(syncStart), .syncEnd(syncEnd), .region(region),
    .activeWin(activeWin), .lpAllowed(lpAllowed)
  );

  task automatic capture();
    sHsa = int'(hsaCyc); sHbp = int'(hbpCyc); sHact = int'(hactCyc); sHline = int'(hlineCyc);
    sVsa = int'(vsaLines); sVbp = int'(vbpLines); sVact = int'(vactLines); sVfp = int'(vfpLines);
    sMode = int'(modeSel); sMask = int'(lpMask);
  endtask

  // model advance (R2 R4 R9)
  always @(posedge clk) begin
    if (!rstN) begin
      mh = 0; mv = 0;
      sHsa = 0; sHbp = 0; sHact = 0; sHline = 0;
      sVsa = 0; sVbp = 0; sVact = 0; sVfp = 0; sMode = 0; sMask = 0;
    end else if (!powerUp) begin
      mh = 0; mv = 0;
      capture();
    end else begin
      int lineLen, frameLen;
      lineLen  = (sHline == 0) ? 1 : sHline;
      frameLen = sVsa + sVbp + sVact + sVfp;
      if (frameLen == 0) frameLen = 1;
      if (mh == lineLen - 1) begin
        mh = 0;
        if (mv == frameLen - 1) begin
          mv = 0;
          capture();
        end else mv = mv + 1;
      end else mh = mh + 1;
    end
  end

  function automatic int expRegion();
    if (mv < sVsa) return 0;
    if (mv < sVsa + sVbp) return 1;
    if (mv < sVsa + sVbp + sVact) begin
      if (mh < sHsa) return 3;
      if (mh < sHsa + sHbp) return 4;
      if (mh < sHsa + sHbp + sHact) return 6;
      return 5;
    end
    return 2;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!powerUp || !rstN) begin
        check("R1 syncStart", int'(syncStart), 0);
        check("R1 syncEnd",   int'(syncEnd),   0);
        check("R1 region",    int'(region),    0);
        check("R1 activeWin", int'(activeWin), 0);
        check("R1 lpAllowed", int'(lpAllowed), 0);
      end else begin
        int rg, lp;
        rg = expRegion();
        lp = (rg == 6) ? 0 : (((sMask >> rg) & 1) | ((sMode == 2 && rg == 5) ? 1 : 0));
        check("R2 syncStart", int'(syncStart), (mh == 0) ? 1 : 0);
        check("R7 syncEnd",   int'(syncEnd),   (sMode == 0 && mh == sHsa) ? 1 : 0);
        check("R6 region",    int'(region),    rg);
        check("R5 activeWin", int'(activeWin), (rg == 6) ? 1 : 0);
        check("R8 lpAllowed", int'(lpAllowed), lp);
      end
    end
  end

  task automatic setCfg(int hsa, int hbp, int hact, int hl, int vsa, int vbp, int vact, int vfp,
                        int mode, int mask);
    hsaCyc = H_W'(hsa); hbpCyc = H_W'(hbp); hactCyc = H_W'(hact); hlineCyc = H_W'(hl);
    vsaLines = V_W'(vsa); vbpLines = V_W'(vbp); vactLines = V_W'(vact); vfpLines = V_W'(vfp);
    modeSel = 2'(mode); lpMask = 6'(mask);
  endtask

  task automatic runCycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    setCfg(2, 3, 6, 16, 1, 2, 3, 2, 0, 6'b101011);
    runCycles(3);
    rstN = 1'b1;
    // R1: powered down, config changes are absorbed without activity
    phase = "R1 powered down";
    runCycles(10);
    setCfg(2, 3, 6, 16, 1, 2, 3, 2, 0, 6'b011101);
    runCycles(10);
    // R2 R3 R4 R7: sync pulse mode over two frames
    phase = "R2 R3 R4 R7 pulse frames";
    powerUp = 1'b1;
    runCycles(300);
    // R9: mid-frame change to sync events, applied at next frame
    phase = "R9 mid-frame change";
    setCfg(1, 1, 4, 10, 2, 1, 2, 1, 1, 6'b010100);
    runCycles(250);
    // R8: burst mode with empty mask opens only the front porch
    phase = "R8 burst";
    setCfg(2, 2, 5, 12, 1, 1, 3, 1, 2, 6'b000000);
    runCycles(300);
    // R3: overlong horizontal parts clamp the front porch
    phase = "R3 front porch clamp";
    setCfg(3, 4, 20, 12, 1, 1, 2, 1, 0, 6'b111111);
    runCycles(200);
    // R4 R2: zero-length line and empty frame
    phase = "R4 zero lengths";
    setCfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 6'b000100);
    runCycles(100);
    // R7: zero sync width gives start and end together
    phase = "R7 zero sync width";
    setCfg(0, 2, 3, 8, 0, 0, 2, 1, 0, 6'b110000);
    runCycles(60);
    // R1: power drop mid-frame restarts from line 0 with fresh config
    phase = "R1 power drop";
    powerUp = 1'b0;
    setCfg(1, 2, 3, 9, 1, 1, 2, 1, 3, 6'b001111);
    runCycles(7);
    powerUp = 1'b1;
    runCycles(200);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog [%s] actual=hung expected=finished", phase);
      finishRun();
    end
  end

endmodule